// File: doc/BRIEF.md
# DMA Channel Control/Status Register Block

This block holds the software-visible registers of one channel of a descriptor-driven DMA engine. Software reaches it through a simple 32-bit register bus with a word address. The bus has a single-cycle write strobe and combinational read data. The engine that fetches descriptors and moves data sits next to it. That engine takes from this block the run, pause, flush and wake requests, the command pointer and three condition-select words. It returns its active, dead and branch-taken indications and eight device status bits.

The status word is never written directly. Software writes the control word instead, which carries a per-bit enable mask in its upper half and the new bit values in its lower half. Only bits that are both enabled and software-owned change, so single request bits can be set or cleared without a read-modify-write. Flush and wake behave as one-shot requests: software raises them and the engine lowers them with an acknowledge. The command pointer is descriptor aligned and can be reloaded by software only while the channel is stopped. The engine can advance it at any time.

Register words by index: 0 control (write only), 1 status (read only), 2 command pointer upper word, 3 command pointer lower word, 4 interrupt condition select, 5 branch condition select, 6 wait condition select. All other indices read as zero and ignore writes.

Top module: `chan_ctl_regs`

## Requirements
- R1: After reset, the run, pause, flush and wake bits, both command pointer words and the three select words are all zero.
- R2: A write to word 0 updates each software-owned status bit (run 15, pause 14, flush 13, wake 12) only when its enable bit (at position +16) is 1, and the bit then takes the value of the matching data bit. A write with an all-zero enable half leaves status unchanged.
- R3: Status (word 1) returns dead at bit 11, active at bit 10, branch-taken at bit 8 and device status at bits 7:0, copied from the engine inputs in the same cycle. Bit 9 and bits 31:16 read 0. Control writes to positions 11, 10, 8 and 7:0 have no effect on them.
- R4: An engine flush or wake acknowledge clears that bit on the next edge, unless a control write in the same cycle sets it, in which case the bit ends up 1.
- R5: Bus writes to words 2 and 3 take effect only while run reads 0. Word 3 bits 3:0 always read 0.
- R6: An engine pointer load replaces the upper 28 bits of word 3 regardless of run, and it takes priority over a bus write to word 3 in the same cycle.
- R7: Words 4, 5 and 6 store full 32-bit values that read back and drive the three select outputs.
- R8: Word 0 and indices 7 to 15 read 0. Writes to word 1 and to indices 7 to 15 change no register.
- R9: The four request outputs always equal the run, pause, flush and wake status bits.
- R10: A control write enabling run and flush with data 0 clears both. A write enabling bits 15:10 with data 0 clears all four software-owned bits and leaves dead and active as the engine drives them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| eng_active | input | 1 | Engine is processing descriptors |
| eng_dead | input | 1 | Engine halted on an error |
| eng_bt | input | 1 | Last descriptor took its branch |
| eng_dev_stat | input | DEV_W (8) | Device status bits |
| eng_flush_ack | input | 1 | Engine finished a flush request |
| eng_wake_ack | input | 1 | Engine consumed a wake request |
| eng_ptr_ld | input | 1 | Engine advances the command pointer |
| eng_ptr_idx | input | 32-PTR_ALIGN (28) | New aligned pointer (upper bits of word 3) |
| req_run | output | 1 | Run request |
| req_pause | output | 1 | Pause request |
| req_flush | output | 1 | Flush request |
| req_wake | output | 1 | Wake request |
| cmd_ptr | output | 64 | Command pointer, upper word first |
| intr_sel | output | 32 | Interrupt condition select |
| br_sel | output | 32 | Branch condition select |
| wait_sel | output | 32 | Wait condition select |

## Verification
The bench goes after the enable mask. An all-zero mask with every data bit set must change nothing, and a design that ignored the mask would start the channel. It also goes after the collision of an acknowledge with a setting write, where a design with the wrong priority would drop a fresh flush or wake request. Pointer writes are aimed at a running channel, and an engine load is issued in the same cycle as a bus write. A missing interlock or a wrong priority shows up as a corrupted descriptor address. Writes to the engine-owned bit positions and to the status word are mixed into random traffic, so a design that latched them would report a false dead or active state.

// File: rtl/chan_ctl_pkg.sv
package chan_ctl_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned MASK_SH = 16;

    // status bit positions
    localparam int unsigned B_RUN    = 15;
    localparam int unsigned B_PAUSE  = 14;
    localparam int unsigned B_FLUSH  = 13;
    localparam int unsigned B_WAKE   = 12;
    localparam int unsigned B_DEAD   = 11;
    localparam int unsigned B_ACTIVE = 10;
    localparam int unsigned B_BT     = 8;

    // register word indices
    localparam logic [ADDR_W-1:0] RI_CTRL    = 4'd0;
    localparam logic [ADDR_W-1:0] RI_STAT    = 4'd1;
    localparam logic [ADDR_W-1:0] RI_PTR_HI  = 4'd2;
    localparam logic [ADDR_W-1:0] RI_PTR_LO  = 4'd3;
    localparam logic [ADDR_W-1:0] RI_SEL_0   = 4'd4;
    localparam int unsigned       NUM_SEL    = 3;

    typedef struct packed {
        logic run;
        logic pause;
        logic flush;
        logic wake;
    } chan_req_t;
endpackage

// File: rtl/chan_ctl_status.sv
module chan_ctl_status
    import chan_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctl_wr,
    input  logic [3:0] ctl_mask,   // enables for run, pause, flush, wake
    input  logic [3:0] ctl_val,
    input  logic      flush_ack,
    input  logic      wake_ack,
    output chan_req_t req_q
);
    chan_req_t req_nxt;
    logic      flush_set;
    logic      wake_set;

    assign flush_set = ctl_wr && ctl_mask[1] && ctl_val[1];
    assign wake_set  = ctl_wr && ctl_mask[0] && ctl_val[0];

    always_comb begin
        req_nxt = req_q;
        if (ctl_wr) begin
            if (ctl_mask[3]) req_nxt.run   = ctl_val[3];
            if (ctl_mask[2]) req_nxt.pause = ctl_val[2];
            if (ctl_mask[1]) req_nxt.flush = ctl_val[1];
            if (ctl_mask[0]) req_nxt.wake  = ctl_val[0];
        end
        if (flush_ack && !flush_set) req_nxt.flush = 1'b0;
        if (wake_ack && !wake_set)   req_nxt.wake  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_nxt;
    end

    // R2
    zero_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ctl_wr || ctl_mask == 4'b0) && !flush_ack && !wake_ack) |=> $stable(req_q));

    // R2
    run_masked_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_mask[3]) |=> (req_q.run == $past(ctl_val[3])));

    // R4
    flush_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_ack && !(ctl_wr && ctl_mask[1] && ctl_val[1])) |=> !req_q.flush);

    // R4
    wake_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_mask[0] && ctl_val[0]) |=> req_q.wake);
endmodule

// File: rtl/chan_ctl_cmdptr.sv
module chan_ctl_cmdptr
    import chan_ctl_pkg::*;
#(
    parameter int unsigned PTR_ALIGN = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run,
    input  logic                       hi_wr,
    input  logic                       lo_wr,
    input  logic [WORD_W-1:0]          hi_data,
    input  logic [WORD_W-1:PTR_ALIGN]  lo_data,
    input  logic                       eng_ld,
    input  logic [WORD_W-1:PTR_ALIGN]  eng_idx,
    output logic [WORD_W-1:0]          ptr_hi,
    output logic [WORD_W-1:PTR_ALIGN]  ptr_idx
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_hi  <= '0;
            ptr_idx <= '0;
        end else begin
            if (hi_wr && !run) ptr_hi <= hi_data;
            if (eng_ld)                 ptr_idx <= eng_idx;
            else if (lo_wr && !run)     ptr_idx <= lo_data;
        end
    end

    // R5
    ptr_lo_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !eng_ld) |=> $stable(ptr_idx));

    // R5
    ptr_hi_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(ptr_hi));

    // R6
    eng_load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_ld |=> (ptr_idx == $past(eng_idx)));
endmodule

// File: rtl/chan_ctl_selregs.sv
module chan_ctl_selregs
    import chan_ctl_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SEL-1:0]             wr_en,
    input  logic [WORD_W-1:0]              wdata,
    output logic [NUM_SEL-1:0][WORD_W-1:0] sel_q
);
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sel_q[g] <= '0;
            else if (wr_en[g]) sel_q[g] <= wdata;
        end

        // R7
        sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en[g] |=> $stable(sel_q[g]));

        // R7
        sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[g] |=> (sel_q[g] == $past(wdata)));
    end
endmodule

// File: rtl/chan_ctl_regs.sv
module chan_ctl_regs
    import chan_ctl_pkg::*;
#(
    parameter int unsigned DEV_W     = 8,
    parameter int unsigned PTR_ALIGN = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wen,
    input  logic [3:0]                bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic                      eng_active,
    input  logic                      eng_dead,
    input  logic                      eng_bt,
    input  logic [DEV_W-1:0]          eng_dev_stat,
    input  logic                      eng_flush_ack,
    input  logic                      eng_wake_ack,
    input  logic                      eng_ptr_ld,
    input  logic [31-PTR_ALIGN:0]     eng_ptr_idx,
    output logic                      req_run,
    output logic                      req_pause,
    output logic                      req_flush,
    output logic                      req_wake,
    output logic [63:0]               cmd_ptr,
    output logic [31:0]               intr_sel,
    output logic [31:0]               br_sel,
    output logic [31:0]               wait_sel
);
    chan_req_t                      req;
    logic [WORD_W-1:0]              ptr_hi;
    logic [WORD_W-1:PTR_ALIGN]      ptr_idx;
    logic [WORD_W-1:0]              ptr_lo_word;
    logic [NUM_SEL-1:0]             sel_wr;
    logic [NUM_SEL-1:0][WORD_W-1:0] sel_q;
    logic [WORD_W-1:0]              stat_word;
    logic                           ctl_wr;

    assign ctl_wr = bus_wen && (bus_addr == RI_CTRL);

    chan_ctl_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_mask  (bus_wdata[MASK_SH+B_RUN:MASK_SH+B_WAKE]),
        .ctl_val   (bus_wdata[B_RUN:B_WAKE]),
        .flush_ack (eng_flush_ack),
        .wake_ack  (eng_wake_ack),
        .req_q     (req)
    );

    chan_ctl_cmdptr #(.PTR_ALIGN(PTR_ALIGN)) u_cmdptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (req.run),
        .hi_wr   (bus_wen && (bus_addr == RI_PTR_HI)),
        .lo_wr   (bus_wen && (bus_addr == RI_PTR_LO)),
        .hi_data (bus_wdata),
        .lo_data (bus_wdata[WORD_W-1:PTR_ALIGN]),
        .eng_ld  (eng_ptr_ld),
        .eng_idx (eng_ptr_idx),
        .ptr_hi  (ptr_hi),
        .ptr_idx (ptr_idx)
    );

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel_dec
        assign sel_wr[g] = bus_wen && (bus_addr == RI_SEL_0 + ADDR_W'(g));
    end

    chan_ctl_selregs u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (sel_wr),
        .wdata (bus_wdata),
        .sel_q (sel_q)
    );

    assign ptr_lo_word = {ptr_idx, {PTR_ALIGN{1'b0}}};

    always_comb begin
        stat_word               = '0;
        stat_word[B_RUN]        = req.run;
        stat_word[B_PAUSE]      = req.pause;
        stat_word[B_FLUSH]      = req.flush;
        stat_word[B_WAKE]       = req.wake;
        stat_word[B_DEAD]       = eng_dead;
        stat_word[B_ACTIVE]     = eng_active;
        stat_word[B_BT]         = eng_bt;
        stat_word[DEV_W-1:0]    = eng_dev_stat;
    end

    always_comb begin
        unique case (bus_addr)
            RI_STAT:         bus_rdata = stat_word;
            RI_PTR_HI:       bus_rdata = ptr_hi;
            RI_PTR_LO:       bus_rdata = ptr_lo_word;
            RI_SEL_0:        bus_rdata = sel_q[0];
            RI_SEL_0 + 4'd1: bus_rdata = sel_q[1];
            RI_SEL_0 + 4'd2: bus_rdata = sel_q[2];
            default:         bus_rdata = '0;
        endcase
    end

    assign req_run   = req.run;
    assign req_pause = req.pause;
    assign req_flush = req.flush;
    assign req_wake  = req.wake;
    assign cmd_ptr   = {ptr_hi, ptr_lo_word};
    assign intr_sel  = sel_q[0];
    assign br_sel    = sel_q[1];
    assign wait_sel  = sel_q[2];

    // R3
    stat_hw_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == RI_STAT) |-> (bus_rdata[B_ACTIVE] == eng_active &&
                                    bus_rdata[B_DEAD] == eng_dead &&
                                    bus_rdata[B_BT] == eng_bt));

    // R10
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == RI_CTRL && bus_wdata[31] && bus_wdata[29] &&
         !bus_wdata[15] && !bus_wdata[13]) |=> (!req_run && !req_flush));
endmodule

// File: tb/chan_ctl_regs_tb_top.sv
`timescale 1ns/10ps
module chan_ctl_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_active = 1'b0, eng_dead = 1'b0, eng_bt = 1'b0;
    logic [7:0]  eng_dev_stat = '0;
    logic        eng_flush_ack = 1'b0, eng_wake_ack = 1'b0, eng_ptr_ld = 1'b0;
    logic [27:0] eng_ptr_idx = '0;
    logic        req_run, req_pause, req_flush, req_wake;
    logic [63:0] cmd_ptr;
    logic [31:0] intr_sel, br_sel, wait_sel;

    // model: run, pause, flush, wake at [3:0]
    logic [3:0]  m_sw = '0;
    logic [31:0] m_hi = '0, m_lo = '0;
    logic [31:0] m_sel [3];
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    chan_ctl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_active(eng_active),
        .eng_dead(eng_dead), .eng_bt(eng_bt), .eng_dev_stat(eng_dev_stat),
        .eng_flush_ack(eng_flush_ack), .eng_wake_ack(eng_wake_ack),
        .eng_ptr_ld(eng_ptr_ld), .eng_ptr_idx(eng_ptr_idx), .req_run(req_run),
        .req_pause(req_pause), .req_flush(req_flush), .req_wake(req_wake),
        .cmd_ptr(cmd_ptr), .intr_sel(intr_sel), .br_sel(br_sel), .wait_sel(wait_sel)
    );

    function automatic logic [31:0] exp_rd(input int a);
        case (a)
            1: exp_rd = {16'b0, m_sw, eng_dead, eng_active, 1'b0, eng_bt, eng_dev_stat};
            2: exp_rd = m_hi;
            3: exp_rd = m_lo;
            4: exp_rd = m_sel[0];
            5: exp_rd = m_sel[1];
            6: exp_rd = m_sel[2];
            default: exp_rd = 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            1: tag_of = "R2 R3 R4";
            2, 3: tag_of = "R5 R6";
            4, 5, 6: tag_of = "R7";
            default: tag_of = "R8";
        endcase
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string pre);
        @(negedge clk);
        for (int a = 0; a < 16; a++) begin
            bus_addr = 4'(a);
            #0.1;
            chk(64'(bus_rdata), 64'(exp_rd(a)), {pre, " ", tag_of(a)});
        end
        chk(64'({req_run, req_pause, req_flush, req_wake}), 64'(m_sw), {pre, " R9"});
        chk(cmd_ptr, {m_hi, m_lo}, {pre, " R5 R6"});
        chk(64'(intr_sel ^ br_sel ^ wait_sel), 64'(m_sel[0] ^ m_sel[1] ^ m_sel[2]), {pre, " R7"});
    endtask

    task automatic cycle(input logic w, input logic [3:0] a, input logic [31:0] d,
                         input logic fa, input logic wa, input logic pl, input logic [27:0] pv,
                         input bit rnd_hw);
        logic [3:0] msk, val, nsw;
        @(negedge clk);
        bus_wen = w; bus_addr = a; bus_wdata = d;
        eng_flush_ack = fa; eng_wake_ack = wa; eng_ptr_ld = pl; eng_ptr_idx = pv;
        if (rnd_hw) begin
            eng_active = 1'($urandom); eng_dead = 1'($urandom);
            eng_bt = 1'($urandom); eng_dev_stat = 8'($urandom);
        end
        msk = (w && a == 4'd0) ? d[31:28] : 4'b0;
        val = d[15:12];
        nsw = (m_sw & ~msk) | (val & msk);
        if (fa && !(msk[1] && val[1])) nsw[1] = 1'b0;
        if (wa && !(msk[0] && val[0])) nsw[0] = 1'b0;
        if (pl) m_lo = {pv, 4'b0};
        else if (w && a == 4'd3 && !m_sw[3]) m_lo = {d[31:4], 4'b0};
        if (w && a == 4'd2 && !m_sw[3]) m_hi = d;
        if (w && a >= 4'd4 && a <= 4'd6) m_sel[a-4] = d;
        m_sw = nsw;
        @(posedge clk);
        #0.2;
        bus_wen = 1'b0; eng_flush_ack = 1'b0; eng_wake_ack = 1'b0; eng_ptr_ld = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        if (!done) begin
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3; i++) m_sel[i] = '0;
        eng_active = 1'b1; eng_dev_stat = 8'h5A;
        repeat (3) @(posedge clk);
        check_all("R1");
        @(negedge clk); rst_n = 1'b1;
        check_all("R1");

        // R2: set run and pause through the mask
        cycle(1, 4'd0, 32'hC000_C000, 0, 0, 0, '0, 0);
        check_all("R2");
        // R2: all-zero mask, all data ones
        cycle(1, 4'd0, 32'h0000_FFFF, 0, 0, 0, '0, 0);
        check_all("R2 zero-mask");
        // R3: mask on engine-owned positions only
        cycle(1, 4'd0, 32'h0DFF_0DFF, 0, 0, 0, '0, 0);
        check_all("R3 hw-owned");
        // R8: write to status word ignored
        cycle(1, 4'd1, 32'hFFFF_FFFF, 0, 0, 0, '0, 0);
        check_all("R8");
        // R5: pointer writes blocked while running
        cycle(1, 4'd3, 32'hDEAD_BEEF, 0, 0, 0, '0, 0);
        cycle(1, 4'd2, 32'h1234_5678, 0, 0, 0, '0, 0);
        check_all("R5 locked");
        // R4: flush set collides with ack, write wins
        cycle(1, 4'd0, 32'h3000_3000, 1, 1, 0, '0, 0);
        check_all("R4 collide");
        // R10: stop
        cycle(1, 4'd0, 32'hA000_0000, 0, 0, 0, '0, 0);
        check_all("R10 stop");
        chk(64'({req_run, req_flush}), 64'(2'b00), "R10 stop bits");
        // R4: ack alone clears wake
        cycle(0, 4'd0, 32'h0, 0, 1, 0, '0, 0);
        check_all("R4 ack");
        // R5: writes now allowed, low bits read zero
        cycle(1, 4'd3, 32'hDEAD_BEEF, 0, 0, 0, '0, 0);
        cycle(1, 4'd2, 32'h1234_5678, 0, 0, 0, '0, 0);
        check_all("R5 open");
        // R6: engine load beats bus write
        cycle(1, 4'd3, 32'h1111_1111, 0, 0, 1, 28'hABCDEF1, 0);
        check_all("R6");
        // R10: reset write with engine-owned bits high
        cycle(1, 4'd0, 32'hF000_F000, 0, 0, 0, '0, 0);
        @(negedge clk); eng_dead = 1'b1; eng_active = 1'b1;
        cycle(1, 4'd0, 32'hFC00_0000, 0, 0, 0, '0, 0);
        check_all("R10 reset");
        bus_addr = 4'd1; #0.1;
        chk(64'(bus_rdata[15:10]), 64'(6'b000011), "R10 reset bits");

        for (int n = 0; n < 600; n++) begin
            int op;
            logic [31:0] d;
            logic [3:0] a;
            op = int'($urandom_range(0, 7));
            d = $urandom;
            a = 4'd0;
            case (op)
                0, 1, 2: begin a = 4'd0; d[31:16] = d[31:16] & 16'($urandom); end
                3: a = 4'(2 + $urandom_range(0, 1));
                4: a = 4'(4 + $urandom_range(0, 2));
                5: a = ($urandom_range(0, 1) != 0) ? 4'd1 : 4'(7 + $urandom_range(0, 8));
                default: a = 4'd0;
            endcase
            cycle(op < 7, a, (op == 6) ? 32'h0 : d, ($urandom_range(0, 3) == 0),
                  ($urandom_range(0, 3) == 0), (op == 7) || ($urandom_range(0, 7) == 0),
                  28'($urandom), 1);
            check_all("rand");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule